// File: doc/BRIEF.md
# Series Switch Edge-Delay Balancing Controller

In a stack of power switches wired in series, a switch that turns on or off slightly ahead of its partner leaves the partner to block more than its share of the bus voltage for a short time. A peak detector in front of each switch position (A and B) captures that brief overvoltage. A slow converter then digitises it, and each finished pair of readings reaches this block as one strobe. The strobe carries a tag that says whether the pair belongs to a turn-on edge or a turn-off edge.

The block keeps two independent fixed-point proportional-integral loops, one for each edge type. Each loop turns its own signed imbalance error into a signed relative delay between the A and B gate commands, counted in modulator steps of 5 ns. The modulator applies these delays to the gate commands on later switching periods, so the imbalance shrinks over several periods rather than within the current one. Gains are powers of two, set by two shift amounts. Both the integrator and the output are clamped to a programmable symmetric limit. An integrator step that would push the output past that limit is discarded.

Top module: `dly_balance_pi`

## Requirements
- R1: A synchronous active-high `rst` drives both delay outputs to zero and clears both integrators. The first update after reset therefore starts from an empty integrator.
- R2: On a turn-on update (`smp_tag` = 0) the error is `ovr_b - ovr_a`. Both codes are treated as unsigned.
- R3: On a turn-off update (`smp_tag` = 1) the error is `ovr_a - ovr_b`. Both codes are treated as unsigned.
- R4: A loop updates only in a cycle where `smp_vld` is 1 and `smp_tag` selects it. In every other cycle its output and its integrator keep their values, whatever the other inputs do.
- R5: The proportional term is the error shifted arithmetically right by `kp_shift`, which rounds toward minus infinity.
- R6: Each update adds the error, shifted arithmetically right by `ki_shift`, to the loop's integrator. The sum is clamped to ±`dly_max`.
- R7: The new output is the proportional term plus the clamped integrator value from R6, clamped to the range −`dly_max` to +`dly_max`.
- R8: If the unclamped sum in R7 falls outside ±`dly_max`, the integrator keeps its old value for that update.
- R9: A delay output takes its new value at the clock edge that samples the strobe. Before that edge it shows the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | One-cycle strobe for a captured sample pair |
| smp_tag | input | 1 | Edge type of the pair: 0 turn-on, 1 turn-off |
| ovr_a | input | ADC_W | Overvoltage code for position A |
| ovr_b | input | ADC_W | Overvoltage code for position B |
| kp_shift | input | SH_W | Right shift for the proportional term |
| ki_shift | input | SH_W | Right shift for the integral increment |
| dly_max | input | DLY_W-1 | Magnitude limit for the integrator and the output |
| dly_on | output | DLY_W | Signed relative turn-on delay, in 5 ns steps |
| dly_off | output | DLY_W | Signed relative turn-off delay, in 5 ns steps |

## Verification
Every result of this block is due exactly one clock edge after its strobe, since the only registers between the inputs and the outputs are the output and integrator flops. The bench drives each strobe at a falling edge and drops it at the next falling edge. It compares both delay outputs at that second falling edge, which is half a cycle after the updating rising edge. One scenario also samples the outputs just after the strobe is driven, to confirm they still show the old value. The bench keeps its own integrator model for each loop, so every later result also depends on whether the anti-windup hold was applied correctly on earlier updates.

// File: rtl/dly_balance_pkg.sv
package dly_balance_pkg;
   typedef enum logic {
      EDGE_ON  = 1'b0,
      EDGE_OFF = 1'b1
   } edge_tag_e;

   localparam int unsigned N_LOOPS = 2;

   function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/dly_clamp.sv
module dly_clamp #(
   parameter int unsigned IN_W  = 16,
   parameter int unsigned OUT_W = 10
) (
   input  logic signed [IN_W-1:0]  val_i,
   input  logic        [OUT_W-2:0] lim_i,
   output logic signed [OUT_W-1:0] val_o,
   output logic                    hit_o
);
   localparam int unsigned LW = OUT_W - 1;

   logic signed [IN_W-1:0] lim_pos;
   logic signed [IN_W-1:0] lim_neg;
   logic                   over_hi;
   logic                   over_lo;

   generate
      if (IN_W <= OUT_W) begin : g_bad_w
         $error("dly_clamp: IN_W must exceed OUT_W");
      end
   endgenerate

   always_comb begin
      lim_pos = $signed({{(IN_W-LW){1'b0}}, lim_i});
      lim_neg = -lim_pos;
      over_hi = (val_i > lim_pos);
      over_lo = (val_i < lim_neg);
      hit_o   = over_hi || over_lo;
      if (over_hi)
         val_o = lim_pos[OUT_W-1:0];
      else if (over_lo)
         val_o = lim_neg[OUT_W-1:0];
      else
         val_o = val_i[OUT_W-1:0];
   end
endmodule

// File: rtl/dly_pi_loop.sv
module dly_pi_loop #(
   parameter int unsigned ADC_W   = 12,
   parameter int unsigned DLY_W   = 10,
   parameter int unsigned SH_W    = 4,
   parameter bit          A_MINUS = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    upd_i,
   input  logic [ADC_W-1:0]        a_i,
   input  logic [ADC_W-1:0]        b_i,
   input  logic [SH_W-1:0]         kp_sh_i,
   input  logic [SH_W-1:0]         ki_sh_i,
   input  logic [DLY_W-2:0]        lim_i,
   output logic signed [DLY_W-1:0] dly_o
);
   import dly_balance_pkg::*;

   localparam int unsigned EW = ADC_W + 1;
   localparam int unsigned SW = max_w(EW, DLY_W) + 2;

   logic signed [EW-1:0]    a_s;
   logic signed [EW-1:0]    b_s;
   logic signed [EW-1:0]    err;
   logic signed [EW-1:0]    p_term;
   logic signed [EW-1:0]    i_term;
   logic signed [SW-1:0]    integ_sum;
   logic signed [DLY_W-1:0] integ_q;
   logic signed [DLY_W-1:0] integ_c;
   logic                    integ_hit;
   logic signed [SW-1:0]    out_sum;
   logic signed [DLY_W-1:0] out_c;
   logic                    out_hit;

   assign a_s = $signed({1'b0, a_i});
   assign b_s = $signed({1'b0, b_i});

   generate
      if (A_MINUS) begin : g_err_ab
         assign err = a_s - b_s;
      end else begin : g_err_ba
         assign err = b_s - a_s;
      end
   endgenerate

   assign p_term    = err >>> kp_sh_i;
   assign i_term    = err >>> ki_sh_i;
   assign integ_sum = SW'(integ_q) + SW'(i_term);

   dly_clamp #(.IN_W(SW), .OUT_W(DLY_W)) integ_clamp_i (
      .val_i (integ_sum),
      .lim_i (lim_i),
      .val_o (integ_c),
      .hit_o (integ_hit)
   );

   assign out_sum = SW'(p_term) + SW'(integ_c);

   dly_clamp #(.IN_W(SW), .OUT_W(DLY_W)) out_clamp_i (
      .val_i (out_sum),
      .lim_i (lim_i),
      .val_o (out_c),
      .hit_o (out_hit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         integ_q <= '0;
         dly_o   <= '0;
      end else if (upd_i) begin
         dly_o <= out_c;
         if (!out_hit)
            integ_q <= integ_c;
      end
   end

   logic unused_hit;
   assign unused_hit = integ_hit;
endmodule

// File: rtl/dly_balance_pi.sv
module dly_balance_pi #(
   parameter int unsigned ADC_W = 12,
   parameter int unsigned DLY_W = 10,
   parameter int unsigned SH_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    smp_vld,
   input  logic                    smp_tag,
   input  logic [ADC_W-1:0]        ovr_a,
   input  logic [ADC_W-1:0]        ovr_b,
   input  logic [SH_W-1:0]         kp_shift,
   input  logic [SH_W-1:0]         ki_shift,
   input  logic [DLY_W-2:0]        dly_max,
   output logic signed [DLY_W-1:0] dly_on,
   output logic signed [DLY_W-1:0] dly_off
);
   import dly_balance_pkg::*;

   generate
      if (ADC_W < 2) begin : g_bad_adc
         $error("dly_balance_pi: ADC_W must be at least 2");
      end
      if (DLY_W < 3) begin : g_bad_dly
         $error("dly_balance_pi: DLY_W must be at least 3");
      end
      if (SH_W < 1 || (2 ** SH_W) > 64) begin : g_bad_sh
         $error("dly_balance_pi: SH_W must be 1 to 6");
      end
   endgenerate

   logic signed [DLY_W-1:0] dly_arr [N_LOOPS];

   generate
      for (genvar g = 0; g < N_LOOPS; g++) begin : g_loop
         logic upd;
         assign upd = smp_vld && (smp_tag == g[0]);

         dly_pi_loop #(
            .ADC_W   (ADC_W),
            .DLY_W   (DLY_W),
            .SH_W    (SH_W),
            .A_MINUS (g == int'(EDGE_OFF))
         ) loop_i (
            .clk     (clk),
            .rst     (rst),
            .upd_i   (upd),
            .a_i     (ovr_a),
            .b_i     (ovr_b),
            .kp_sh_i (kp_shift),
            .ki_sh_i (ki_shift),
            .lim_i   (dly_max),
            .dly_o   (dly_arr[g])
         );
      end
   endgenerate

   assign dly_on  = dly_arr[int'(EDGE_ON)];
   assign dly_off = dly_arr[int'(EDGE_OFF)];
endmodule

// File: rtl/dly_balance_pi_chk.sv
module dly_balance_pi_chk #(
   parameter int unsigned DLY_W = 10
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    smp_vld,
   input logic                    smp_tag,
   input logic [DLY_W-2:0]        dly_max,
   input logic signed [DLY_W-1:0] dly_on,
   input logic signed [DLY_W-1:0] dly_off
);
   logic signed [DLY_W-1:0] lim_s;
   assign lim_s = $signed({1'b0, dly_max});

   // R1
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (dly_on == '0 && dly_off == '0));

   // R4
   on_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(smp_vld && !smp_tag) |=> $stable(dly_on));

   // R4
   off_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(smp_vld && smp_tag) |=> $stable(dly_off));

   // R7
   on_bound_chk: assert property (@(posedge clk) disable iff (rst)
      (smp_vld && !smp_tag) |=> (dly_on <= $past(lim_s) && dly_on >= -$past(lim_s)));

   // R7
   off_bound_chk: assert property (@(posedge clk) disable iff (rst)
      (smp_vld && smp_tag) |=> (dly_off <= $past(lim_s) && dly_off >= -$past(lim_s)));
endmodule

bind dly_balance_pi dly_balance_pi_chk #(.DLY_W(DLY_W)) chk_i (
   .clk     (clk),
   .rst     (rst),
   .smp_vld (smp_vld),
   .smp_tag (smp_tag),
   .dly_max (dly_max),
   .dly_on  (dly_on),
   .dly_off (dly_off)
);

// File: tb/dly_balance_pi_tb_top.sv
module dly_balance_pi_tb_top;
   localparam int ADC_W = 12;
   localparam int DLY_W = 10;
   localparam int SH_W  = 4;

   logic                    clk = 1'b0;
   logic                    rst = 1'b1;
   logic                    smp_vld = 1'b0;
   logic                    smp_tag = 1'b0;
   logic [ADC_W-1:0]        ovr_a = '0;
   logic [ADC_W-1:0]        ovr_b = '0;
   logic [SH_W-1:0]         kp_shift = '0;
   logic [SH_W-1:0]         ki_shift = '0;
   logic [DLY_W-2:0]        dly_max = '0;
   logic signed [DLY_W-1:0] dly_on;
   logic signed [DLY_W-1:0] dly_off;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int m_int [2];
   int m_out [2];

   always #10 clk = ~clk;

   dly_balance_pi #(.ADC_W(ADC_W), .DLY_W(DLY_W), .SH_W(SH_W)) dut_i (
      .clk (clk), .rst (rst), .smp_vld (smp_vld), .smp_tag (smp_tag),
      .ovr_a (ovr_a), .ovr_b (ovr_b), .kp_shift (kp_shift),
      .ki_shift (ki_shift), .dly_max (dly_max),
      .dly_on (dly_on), .dly_off (dly_off)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int clamp(input int v, input int lim);
      if (v > lim) return lim;
      if (v < -lim) return -lim;
      return v;
   endfunction

   // Reference model of one update, built from R2, R3 and R5 to R8
   task automatic model_step(input bit tag, input int a, input int b);
      int err, p, ic, raw, lim;
      lim = int'(dly_max);
      err = tag ? (a - b) : (b - a);
      p   = err >>> kp_shift;
      ic  = clamp(m_int[tag] + (err >>> ki_shift), lim);
      raw = p + ic;
      m_out[tag] = clamp(raw, lim);
      if (raw <= lim && raw >= -lim) m_int[tag] = ic;
   endtask

   task automatic send(input bit tag, input int a, input int b, input string req);
      @(negedge clk);
      smp_vld = 1'b1; smp_tag = tag; ovr_a = a[ADC_W-1:0]; ovr_b = b[ADC_W-1:0];
      @(negedge clk);
      smp_vld = 1'b0;
      model_step(tag, a, b);
      check(req, int'(dly_on), m_out[0]);
      check(req, int'(dly_off), m_out[1]);
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      m_int = '{0, 0}; m_out = '{0, 0};
      check("R1 dly_on", int'(dly_on), 0);
      check("R1 dly_off", int'(dly_off), 0);
   endtask

   task automatic t_turn_on();
      kp_shift = 4'd1; ki_shift = 4'd3; dly_max = 9'd200;
      // R2: err 40, p 20, i 5 -> 25
      send(1'b0, 100, 140, "R2 on first");
      check("R2 explicit", int'(dly_on), 25);
      // R6: integrator now 10, p 20 -> 30
      send(1'b0, 100, 140, "R6 on accumulate");
      check("R6 explicit", int'(dly_on), 30);
      // R9: output must not move before the edge
      @(negedge clk);
      smp_vld = 1'b1; smp_tag = 1'b0; ovr_a = 12'd0; ovr_b = 12'd80;
      #2 check("R9 before edge", int'(dly_on), 30);
      @(negedge clk);
      smp_vld = 1'b0;
      model_step(1'b0, 0, 80);
      check("R9 after edge", int'(dly_on), m_out[0]);
   endtask

   task automatic t_turn_off();
      int on_before;
      on_before = int'(dly_on);
      kp_shift = 4'd0; ki_shift = 4'd2;
      // R3: err 50, p 50, i 12 -> 62
      send(1'b1, 300, 250, "R3 off");
      check("R3 explicit", int'(dly_off), 62);
      check("R4 on untouched", int'(dly_on), on_before);
   endtask

   task automatic t_ignore();
      int on_v, off_v;
      on_v = int'(dly_on); off_v = int'(dly_off);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         ovr_a = 12'(k * 300); ovr_b = 12'(4000 - k * 100); smp_tag = k[0];
      end
      @(negedge clk);
      check("R4 idle on", int'(dly_on), on_v);
      check("R4 idle off", int'(dly_off), off_v);
      // R4: integrators unchanged, model follows without idle steps
      send(1'b0, 10, 10, "R4 on integ kept");
      send(1'b1, 10, 10, "R4 off integ kept");
   endtask

   task automatic t_neg_shift();
      do_reset();
      kp_shift = 4'd1; ki_shift = 4'd2; dly_max = 9'd100;
      // R5: err -5 -> p -3, i -2 -> -5
      send(1'b0, 105, 100, "R5 floor shift");
      check("R5 explicit", int'(dly_on), -5);
   endtask

   task automatic t_saturate();
      do_reset();
      kp_shift = 4'd0; ki_shift = 4'd0; dly_max = 9'd20;
      // R7: err 100 -> raw 120 clamped to 20; R8 integrator stays 0
      send(1'b0, 0, 100, "R7 clamp high");
      check("R7 explicit", int'(dly_on), 20);
      // R8: err -5 -> p -5 + integ(0-5) = -10
      send(1'b0, 5, 0, "R8 integ held");
      check("R8 explicit", int'(dly_on), -10);
      // R7 negative: turn-off err -300
      send(1'b1, 0, 300, "R7 clamp low");
      check("R7 low explicit", int'(dly_off), -20);
      send(1'b1, 3, 0, "R8 off integ held");
      check("R8 off explicit", int'(dly_off), 6);
   endtask

   task automatic t_mid_reset();
      send(1'b0, 0, 7, "R6 before reset");
      do_reset();
      kp_shift = 4'd5; ki_shift = 4'd0; dly_max = 9'd255;
      // R1: fresh integrator: err 9 -> p 0 + 9
      send(1'b0, 1, 10, "R1 fresh integ");
      check("R1 explicit", int'(dly_on), 9);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      m_int = '{0, 0}; m_out = '{0, 0};
      check("R1 start on", int'(dly_on), 0);
      check("R1 start off", int'(dly_off), 0);
      t_turn_on();
      t_turn_off();
      t_ignore();
      t_neg_shift();
      t_saturate();
      t_mid_reset();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule